// File: doc/BRIEF.md
# Detector Channel Fault Shutdown Controller

This block guards seven independently powered detector channels. Each channel has a level input that reports an overlight condition from the detector, and an active-low overcurrent flag from that channel's load switch. The block drives one registered power-enable output per channel. It also drives one registered fault-status output per channel.

A command handler turns channels on and off with single-cycle request pulses, one bit per channel. An overcurrent flag forces its channel off as soon as it has been synchronized. An overlight level must stay asserted for a programmable number of consecutive clock cycles before it trips. With a 50 MHz clock, 50 ms of persistence is 2,500,000 cycles. A trip latches the channel off and raises its fault-status bit. The channel stays off until a later turn-on command arrives while both of its fault inputs are quiet.

Both fault inputs cross into the clock domain through two-flop synchronizers. The persistence count is a parameter, so a simulation can use a short window.

Top module: `chan_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every `pwr_en` bit and every `fault_stat` bit is 0.
- R2: A `cmd_on` pulse on bit i sets `pwr_en[i]` at the next clock edge, provided that channel is not latched off by a fault. No other channel's outputs change.
- R3: A `cmd_off` pulse on bit i clears `pwr_en[i]` at the next clock edge. If `cmd_on[i]` and `cmd_off[i]` are both high in the same cycle, the channel turns off.
- R4: When `oc_n_in[i]` is driven to 0 (the flag is active low), `pwr_en[i]` falls and `fault_stat[i]` rises on the third rising clock edge after the change.
- R5: If `olt_in[i]` (active high) is sampled high on PERSIST_CYCLES consecutive edges, the channel trips. `pwr_en[i]` falls and `fault_stat[i]` rises on edge PERSIST_CYCLES+2, counted from the first high sample. The trip happens even if the input drops right after the last high sample.
- R6: An overlight level shorter than PERSIST_CYCLES sampled cycles causes no trip. A single low sample restarts the count, so two runs of PERSIST_CYCLES-1 high samples separated by one low sample cause no trip.
- R7: After a trip, the channel stays off and `fault_stat[i]` stays 1 after both fault inputs return to their inactive levels, until a turn-on command is given.
- R8: A `cmd_on[i]` pulse is ignored while channel i is latched and either of its synchronized fault inputs is active. `pwr_en[i]` stays 0 and `fault_stat[i]` stays 1.
- R9: A `cmd_on[i]` pulse given while channel i is latched and both synchronized fault inputs are inactive does two things at the next edge: it clears `fault_stat[i]` and sets `pwr_en[i]`.
- R10: Channels are independent. A fault or command on one channel leaves every other channel's `pwr_en` and `fault_stat` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| olt_in | input | NUM_CH | Overlight level per channel, active high, asynchronous |
| oc_n_in | input | NUM_CH | Overcurrent flag per channel, active low, asynchronous |
| cmd_on | input | NUM_CH | Single-cycle turn-on request per channel |
| cmd_off | input | NUM_CH | Single-cycle turn-off request per channel |
| pwr_en | output | NUM_CH | Registered power enable per channel |
| fault_stat | output | NUM_CH | Registered flag, set while a channel is latched off by a fault |

## Verification
The bench drives four kinds of overlight pattern:
- A level held continuously, sampled cycle by cycle around the trip edge. This pins the PERSIST_CYCLES+2 latency exactly.
- A run that is exactly PERSIST_CYCLES long and then drops. This separates a correct threshold from one that is off by one.
- Two runs one cycle shorter than the threshold, split by one low cycle. A counter that does not restart would trip here.
- A short run overlapping a clear attempt. This shows that the clear waits for quiet inputs.

Overcurrent is checked edge by edge to confirm the synchronizer depth. It is then released, to show that the latch holds. Command tests include simultaneous on and off requests to fix the priority. A final pair of concurrent faults, cleared one channel at a time, shows that the channels do not interact.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // Width of a counter that must hold values 0 .. limit-1
  function automatic int cnt_w(input int limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int   WIDTH   = 7,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cg_persist.sv
module cg_persist #(
  parameter int LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic trip
);
  localparam int         W   = cg_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  // Counts consecutive high samples; any low sample restarts from zero
  always_ff @(posedge clk) begin
    if (rst || !level) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign trip = level && (cnt == TOP);
endmodule

// File: rtl/cg_chan_ctl.sv
module cg_chan_ctl (
  input  logic clk,
  input  logic rst,
  input  logic olt_s,
  input  logic oc_n_s,
  input  logic ol_trip,
  input  logic req_on,
  input  logic req_off,
  output logic en,
  output logic latched
);
  logic fault_now, quiet, lat_nx, en_nx;

  always_comb begin
    fault_now = ol_trip | ~oc_n_s;
    quiet     = ~olt_s & oc_n_s;
    // Latch: set on fault, clear only by turn-on with quiet inputs
    if (fault_now)                  lat_nx = 1'b1;
    else if (latched && req_on && quiet) lat_nx = 1'b0;
    else                            lat_nx = latched;
    // Enable: fault and off win over on
    if (fault_now)                  en_nx = 1'b0;
    else if (req_off)               en_nx = 1'b0;
    else if (req_on && (!latched || quiet)) en_nx = 1'b1;
    else                            en_nx = en;
    en_nx = en_nx & ~lat_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      latched <= 1'b0;
    end else begin
      en      <= en_nx;
      latched <= lat_nx;
    end
  end
endmodule

// File: rtl/chan_guard.sv
module chan_guard #(
  parameter int NUM_CH         = 7,
  parameter int PERSIST_CYCLES = 2500000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] olt_in,
  input  logic [NUM_CH-1:0] oc_n_in,
  input  logic [NUM_CH-1:0] cmd_on,
  input  logic [NUM_CH-1:0] cmd_off,
  output logic [NUM_CH-1:0] pwr_en,
  output logic [NUM_CH-1:0] fault_stat
);
  logic [NUM_CH-1:0] olt_s, oc_n_s, ol_trip;

  cg_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ol (
    .clk(clk), .rst(rst), .d(olt_in), .q(olt_s));

  cg_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_oc (
    .clk(clk), .rst(rst), .d(oc_n_in), .q(oc_n_s));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cg_persist #(.LIMIT(PERSIST_CYCLES)) u_persist (
      .clk(clk), .rst(rst), .level(olt_s[c]), .trip(ol_trip[c]));

    cg_chan_ctl u_ctl (
      .clk(clk), .rst(rst),
      .olt_s(olt_s[c]), .oc_n_s(oc_n_s[c]), .ol_trip(ol_trip[c]),
      .req_on(cmd_on[c]), .req_off(cmd_off[c]),
      .en(pwr_en[c]), .latched(fault_stat[c]));
  end
endmodule

// File: rtl/cg_chk.sv
module cg_chk #(
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] olt_in,
  input logic [NUM_CH-1:0] oc_n_in,
  input logic [NUM_CH-1:0] cmd_on,
  input logic [NUM_CH-1:0] cmd_off,
  input logic [NUM_CH-1:0] pwr_en,
  input logic [NUM_CH-1:0] fault_stat
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd4) age <= age + 1'b1;
  end

  // R2
  en_rise_needs_on_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1) |-> ((pwr_en & ~$past(pwr_en) & ~$past(cmd_on)) == '0));

  // R3
  off_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1) |-> (($past(cmd_off) & pwr_en) == '0));

  // R4
  overcurrent_off_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3) |-> ((~$past(oc_n_in, 3) & pwr_en) == '0));

  // R7
  latched_off_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_stat & pwr_en) == '0);

  // R9
  clear_needs_on_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1) |-> (($past(fault_stat) & ~fault_stat & ~$past(cmd_on)) == '0));
endmodule

bind chan_guard cg_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_chan_guard.sv
module tb_chan_guard;
  localparam int N = 7;
  localparam int P = 20;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] olt_in, oc_n_in, cmd_on, cmd_off, pwr_en, fault_stat;

  always #4 clk = ~clk;

  chan_guard #(.NUM_CH(N), .PERSIST_CYCLES(P), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .olt_in(olt_in), .oc_n_in(oc_n_in),
    .cmd_on(cmd_on), .cmd_off(cmd_off), .pwr_en(pwr_en), .fault_stat(fault_stat));

  typedef struct {
    string        tag;
    logic [N-1:0] en;
    logic [N-1:0] st;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwr_en !== e.en || fault_stat !== e.st) begin
        errors++;
        $display("FAIL %s: pwr_en=%h fault_stat=%h expected pwr_en=%h fault_stat=%h",
                 e.tag, pwr_en, fault_stat, e.en, e.st);
      end
    end
  end

  // Driver side: expectation for the state after the next rising edge
  task automatic chk(input string tag, input logic [N-1:0] en, input logic [N-1:0] st);
    @(posedge clk);
    q.push_back('{tag, en, st});
    @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] on_m, input logic [N-1:0] off_m);
    cmd_on  = on_m;
    cmd_off = off_m;
    @(negedge clk);
    cmd_on  = '0;
    cmd_off = '0;
  endtask

  initial begin
    rst = 1'b1; olt_in = '0; oc_n_in = '1; cmd_on = '0; cmd_off = '0;
    wait_n(3);
    rst = 1'b0;
    chk("R1 reset", 7'h00, 7'h00);

    pulse(7'h7F, 7'h00); chk("R2 all on", 7'h7F, 7'h00);
    pulse(7'h00, 7'h04); chk("R3 off ch2", 7'h7B, 7'h00);
    pulse(7'h08, 7'h08); chk("R3 on+off ch3", 7'h73, 7'h00);
    pulse(7'h0C, 7'h00); chk("R2 on ch2 ch3", 7'h7F, 7'h00);

    // Overcurrent timing on ch0, edge by edge
    oc_n_in[0] = 1'b0;
    chk("R4 edge1", 7'h7F, 7'h00);
    chk("R4 edge2", 7'h7F, 7'h00);
    chk("R4 edge3", 7'h7E, 7'h01);
    pulse(7'h01, 7'h00); chk("R8 on during oc", 7'h7E, 7'h01);
    oc_n_in[0] = 1'b1;
    wait_n(4);
    chk("R7 held after release", 7'h7E, 7'h01);
    olt_in[0] = 1'b1;
    wait_n(3);
    pulse(7'h01, 7'h00); chk("R8 on during overlight", 7'h7E, 7'h01);
    olt_in[0] = 1'b0;
    wait_n(4);
    pulse(7'h01, 7'h00); chk("R9 clear ch0", 7'h7F, 7'h00);

    // Two sub-threshold runs split by one low sample
    olt_in[4] = 1'b1; wait_n(P-1);
    olt_in[4] = 1'b0; wait_n(1);
    olt_in[4] = 1'b1; wait_n(P-1);
    olt_in[4] = 1'b0; wait_n(5);
    chk("R6 no trip", 7'h7F, 7'h00);

    // Run of exactly P samples, then drop
    olt_in[4] = 1'b1; wait_n(P);
    olt_in[4] = 1'b0; wait_n(4);
    chk("R5 exact threshold", 7'h6F, 7'h10);
    pulse(7'h10, 7'h00); chk("R9 clear ch4", 7'h7F, 7'h00);

    // Continuous level on ch5, trip edge located exactly
    olt_in[5] = 1'b1;
    for (int i = 0; i < P + 1; i++) chk("R5 before trip", 7'h7F, 7'h00);
    chk("R5 trip edge", 7'h5F, 7'h20);
    pulse(7'h20, 7'h00); chk("R8 on while high", 7'h5F, 7'h20);
    olt_in[5] = 1'b0;
    wait_n(4);
    chk("R7 held ch5", 7'h5F, 7'h20);
    pulse(7'h20, 7'h00); chk("R9 clear ch5", 7'h7F, 7'h00);

    // Independent faults on ch1 and ch6
    oc_n_in[1] = 1'b0; oc_n_in[6] = 1'b0;
    wait_n(4);
    chk("R10 two faults", 7'h3D, 7'h42);
    oc_n_in[1] = 1'b1; oc_n_in[6] = 1'b1;
    wait_n(4);
    pulse(7'h02, 7'h00); chk("R10 clear ch1 only", 7'h3F, 7'h40);
    pulse(7'h40, 7'h00); chk("R10 clear ch6", 7'h7F, 7'h00);

    wait_n(2);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule